// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block performs the two double-width shifts of an integer execution unit. A destination operand moves left or right by a count, and the bit positions it leaves empty are filled from a second source operand rather than with zeros or sign copies. In effect it shifts across the joined pair {destination, source} and keeps one operand's worth of bits. The source operand is only read.

Each request presents both operands, a count, a direction and an operand size of 16 or 32 bits. The result, the carry-out (the last bit pushed out of the destination) and an out-of-range flag are registered. They appear with a valid strobe one clock after the request, and they hold their values until the next request.

Top module: `funnel_shift_dbl`

## Requirements
- R1: With dir=0 (left) and size_full=1, a count c in 1..31 gives result = (dst << c) with its low c bits taken from src[31:32-c].
- R2: With dir=1 (right) and size_full=1, a count c in 1..31 gives result = (dst >> c) with its high c bits taken from src[c-1:0].
- R3: Only the low 5 bits of the count input are used. Count bits 7..5 have no effect on the result or on the carry.
- R4: A masked count of zero returns the destination unchanged (the low 16 bits, zero-extended, in 16-bit mode). The carry output keeps its previous value.
- R5: For a left shift with a non-zero count c, the carry becomes dst[W-c], where W is 32 or 16 according to the operand size.
- R6: For a right shift with a non-zero count c, the carry becomes dst[c-1].
- R7: With size_full=0, only bits 15..0 of dst and src take part. Result bits 31..16 are zero, and a count of 16 is legal: the result equals src[15:0].
- R8: With size_full=0 and a masked count of 17..31, the result is zero, out_of_range is 1 and the carry holds. Every other request clears out_of_range.
- R9: res_valid is 1 in exactly the cycle after a cycle with req=1. Without a request, the result, carry and out_of_range hold their values.
- R10: After reset, result, carry, out_of_range and res_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Operation request, sampled each clock |
| dir | input | 1 | 0 = shift left double, 1 = shift right double |
| size_full | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| dst | input | 32 | Operand that is shifted |
| src | input | 32 | Operand that supplies the fill bits |
| count | input | 8 | Shift count, low 5 bits used |
| result | output | 32 | Registered shifted value |
| carry | output | 1 | Registered last bit shifted out |
| out_of_range | output | 1 | Registered 16-bit over-count flag |
| res_valid | output | 1 | Strobe one clock after a request |

## Verification
The bench builds the block with its default widths: 32-bit and 16-bit operands and an 8-bit count input of which 5 bits are used. These widths make every masked count from 0 to 31 reachable in both sizes. That covers the 16-bit boundary at 16 and the over-range counts 17 to 31, as well as counts of 32 and above that wrap to zero. Random operands and counts mixed with idle cycles exercise carry retention across zero counts, over-range requests and gaps between requests.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic {
    FSH_LEFT  = 1'b0,
    FSH_RIGHT = 1'b1
  } fsh_dir_e;

  typedef enum logic {
    FSH_HALF = 1'b0,
    FSH_FULL = 1'b1
  } fsh_size_e;
endpackage

// File: rtl/fsh_count_dec.sv
module fsh_count_dec #(
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 5,
  parameter int HALF_W   = 16
) (
  input  logic [CNT_IN_W-1:0] count_in,
  input  logic                size_full,
  output logic [CNT_W-1:0]    mcount,
  output logic                cnt_zero,
  output logic                cnt_over
);
  localparam int HALF_LIM = HALF_W;

  function automatic logic over_half(input logic [CNT_W-1:0] c);
    return int'(c) > HALF_LIM;
  endfunction

  always_comb begin
    mcount   = count_in[CNT_W-1:0];
    cnt_zero = (mcount == '0);
    cnt_over = (size_full == fsh_pkg::FSH_HALF) && over_half(mcount);
  end
endmodule

// File: rtl/fsh_core.sv
module fsh_core #(
  parameter int W     = 32,
  parameter int CNT_W = 5
) (
  input  logic             dir,
  input  logic [W-1:0]     d,
  input  logic [W-1:0]     s,
  input  logic [CNT_W-1:0] c,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] dbl_left(input logic [W-1:0] hi,
                                            input logic [W-1:0] lo,
                                            input logic [CNT_W-1:0] n);
    logic [PW-1:0] cat;
    cat = {hi, lo} << n;
    return cat[PW-1:W];
  endfunction

  function automatic logic [W-1:0] dbl_right(input logic [W-1:0] lo,
                                             input logic [W-1:0] hi,
                                             input logic [CNT_W-1:0] n);
    logic [PW-1:0] cat;
    cat = {hi, lo} >> n;
    return cat[W-1:0];
  endfunction

  function automatic logic last_left(input logic [W-1:0] hi,
                                     input logic [W-1:0] lo,
                                     input logic [CNT_W-1:0] n);
    logic [PW-1:0] cat;
    cat = {hi, lo} << (n - 1'b1);
    return cat[PW-1];
  endfunction

  function automatic logic last_right(input logic [W-1:0] lo,
                                      input logic [W-1:0] hi,
                                      input logic [CNT_W-1:0] n);
    logic [PW-1:0] cat;
    cat = {hi, lo} >> (n - 1'b1);
    return cat[0];
  endfunction

  always_comb begin
    if (dir == fsh_pkg::FSH_RIGHT) begin
      res  = dbl_right(d, s, c);
      cout = last_right(d, s, c);
    end else begin
      res  = dbl_left(d, s, c);
      cout = last_left(d, s, c);
    end
  end
endmodule

// File: rtl/fsh_outreg.sv
module fsh_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] next_res,
  input  logic         next_carry,
  input  logic         cnt_zero,
  input  logic         cnt_over,
  output logic [W-1:0] res_q,
  output logic         carry_q,
  output logic         range_q,
  output logic         valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      range_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req;
      if (req) begin
        range_q <= cnt_over;
        if (cnt_over) begin
          res_q <= '0;
        end else begin
          res_q <= next_res;
          if (!cnt_zero) carry_q <= next_carry;
        end
      end
    end
  end
endmodule

// File: rtl/funnel_shift_dbl.sv
module funnel_shift_dbl #(
  parameter int FULL_W   = 32,
  parameter int HALF_W   = 16,
  parameter int CNT_IN_W = 8,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                dir,
  input  logic                size_full,
  input  logic [FULL_W-1:0]   dst,
  input  logic [FULL_W-1:0]   src,
  input  logic [CNT_IN_W-1:0] count,
  output logic [FULL_W-1:0]   result,
  output logic                carry,
  output logic                out_of_range,
  output logic                res_valid
);
  localparam int PAD_W = FULL_W - HALF_W;

  logic [CNT_W-1:0]  mcount;
  logic              cnt_zero;
  logic              cnt_over;
  logic [FULL_W-1:0] full_res;
  logic              full_cout;
  logic [HALF_W-1:0] half_res;
  logic              half_cout;
  logic [FULL_W-1:0] sel_res;
  logic              sel_cout;

  fsh_count_dec #(.CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W), .HALF_W(HALF_W)) u_dec (
    .count_in (count),
    .size_full(size_full),
    .mcount   (mcount),
    .cnt_zero (cnt_zero),
    .cnt_over (cnt_over)
  );

  for (genvar g = 0; g < 2; g++) begin : g_width
    if (g == 0) begin : g_full
      fsh_core #(.W(FULL_W), .CNT_W(CNT_W)) u_core (
        .dir (dir),
        .d   (dst),
        .s   (src),
        .c   (mcount),
        .res (full_res),
        .cout(full_cout)
      );
    end else begin : g_half
      fsh_core #(.W(HALF_W), .CNT_W(CNT_W)) u_core (
        .dir (dir),
        .d   (dst[HALF_W-1:0]),
        .s   (src[HALF_W-1:0]),
        .c   (mcount),
        .res (half_res),
        .cout(half_cout)
      );
    end
  end

  always_comb begin
    if (size_full == fsh_pkg::FSH_FULL) begin
      sel_res  = full_res;
      sel_cout = full_cout;
    end else begin
      sel_res  = {{PAD_W{1'b0}}, half_res};
      sel_cout = half_cout;
    end
  end

  fsh_outreg #(.W(FULL_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .next_res  (sel_res),
    .next_carry(sel_cout),
    .cnt_zero  (cnt_zero),
    .cnt_over  (cnt_over),
    .res_q     (result),
    .carry_q   (carry),
    .range_q   (out_of_range),
    .valid_q   (res_valid)
  );
endmodule

// File: rtl/fsh_checker.sv
module fsh_checker #(
  parameter int FULL_W = 32,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              size_full,
  input logic [FULL_W-1:0] dst,
  input logic              cnt_zero,
  input logic              cnt_over,
  input logic [FULL_W-1:0] result,
  input logic              carry,
  input logic              out_of_range,
  input logic              res_valid
);
  assert_valid_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!res_valid && $stable(result) && $stable(carry) && $stable(out_of_range)));

  assert_zero_count_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cnt_zero) |=> $stable(carry));

  assert_zero_count_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cnt_zero && size_full) |=> (result == $past(dst)));

  assert_over_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cnt_over) |=> (result == '0 && out_of_range && $stable(carry)));

  assert_over_only_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_over |-> !size_full);

  assert_half_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !size_full) |=> (result[FULL_W-1:HALF_W] == '0));

  assert_range_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cnt_over) |=> !out_of_range);
endmodule

bind funnel_shift_dbl fsh_checker #(.FULL_W(FULL_W), .HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .size_full   (size_full),
  .dst         (dst),
  .cnt_zero    (cnt_zero),
  .cnt_over    (cnt_over),
  .result      (result),
  .carry       (carry),
  .out_of_range(out_of_range),
  .res_valid   (res_valid)
);

// File: tb/sim_funnel_shift_dbl.sv
`timescale 1ns/1ps
module sim_funnel_shift_dbl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        dir = 1'b0;
  logic        size_full = 1'b1;
  logic [31:0] dst = '0;
  logic [31:0] src = '0;
  logic [7:0]  count = '0;
  logic [31:0] result;
  logic        carry;
  logic        out_of_range;
  logic        res_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] e_res = '0;
  logic        e_carry = 1'b0;
  logic        e_range = 1'b0;
  logic        e_valid = 1'b0;
  string       e_tag = "R10";

  always #4 clk = ~clk;

  funnel_shift_dbl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .dir(dir), .size_full(size_full),
    .dst(dst), .src(src), .count(count), .result(result), .carry(carry),
    .out_of_range(out_of_range), .res_valid(res_valid)
  );

  // Behavioural model: each output bit is picked from whichever operand it lands in
  task automatic model(input bit rq, input bit dr, input bit full,
                       input logic [31:0] d, input logic [31:0] s, input logic [7:0] cn);
    int w;
    int c;
    e_valid = rq;
    if (!rq) return;
    w = full ? 32 : 16;
    c = int'(cn) % 32;
    if (!full && c > 16) begin
      e_res   = '0;
      e_range = 1'b1;
      return;
    end
    e_range = 1'b0;
    e_res   = '0;
    for (int i = 0; i < w; i++) begin
      int p;
      if (!dr) begin
        p = i - c;
        e_res[i] = (p >= 0) ? d[p] : s[w + p];
      end else begin
        p = i + c;
        e_res[i] = (p < w) ? d[p] : s[p - w];
      end
    end
    if (c != 0) e_carry = dr ? d[c - 1] : d[w - c];
  endtask

  task automatic compare();
    checks++;
    if (result !== e_res || carry !== e_carry || out_of_range !== e_range || res_valid !== e_valid) begin
      errors++;
      $display("FAIL %s: got res=%h c=%b r=%b v=%b expected res=%h c=%b r=%b v=%b",
               e_tag, result, carry, out_of_range, res_valid, e_res, e_carry, e_range, e_valid);
    end
  endtask

  task automatic cyc(input string tag, input bit rq, input bit dr, input bit full,
                     input logic [31:0] d, input logic [31:0] s, input logic [7:0] cn);
    @(negedge clk);
    compare();
    req = rq; dir = dr; size_full = full; dst = d; src = s; count = cn;
    model(rq, dr, full, d, s, cn);
    e_tag = tag;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9: watchdog expired, got done=0 expected done=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                 // R10 reset state
    rst_n = 1'b1;
    e_tag = "R10";
    cyc("R1", 1, 0, 1, 32'h1234_5678, 32'hE000_0000, 8'd3);
    cyc("R2", 1, 1, 1, 32'h1234_5678, 32'h0000_000B, 8'd4);
    cyc("R5", 1, 0, 1, 32'h8000_0000, 32'h0, 8'd1);
    cyc("R6", 1, 1, 1, 32'h0000_0001, 32'h0, 8'd1);
    cyc("R1", 1, 0, 1, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 8'd31);
    cyc("R2", 1, 1, 1, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 8'd31);
    cyc("R3", 1, 0, 1, 32'h1234_5678, 32'hE000_0000, 8'h23);
    cyc("R3", 1, 1, 1, 32'h1234_5678, 32'hCAFE_0003, 8'hE4);
    cyc("R4", 1, 0, 1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 8'd0);
    cyc("R4", 1, 1, 1, 32'h0BAD_F00D, 32'hFFFF_FFFF, 8'h20);
    cyc("R4", 1, 0, 0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 8'h40);
    cyc("R7", 1, 0, 0, 32'hFFFF_1234, 32'hABCD_8765, 8'd5);
    cyc("R7", 1, 1, 0, 32'hFFFF_1234, 32'hABCD_8765, 8'd5);
    cyc("R7", 1, 0, 0, 32'h5555_8001, 32'h1111_BEEF, 8'd16);
    cyc("R7", 1, 1, 0, 32'h5555_8001, 32'h1111_BEEF, 8'd16);
    cyc("R8", 1, 0, 0, 32'h0000_FFFF, 32'h0000_FFFF, 8'd17);
    cyc("R8", 1, 1, 0, 32'h0000_FFFF, 32'h0000_FFFF, 8'd31);
    cyc("R8", 1, 1, 1, 32'h0000_FFFF, 32'h0000_FFFF, 8'd17);
    cyc("R9", 0, 0, 1, 32'h1111_1111, 32'h2222_2222, 8'd7);
    cyc("R9", 0, 1, 0, 32'h3333_3333, 32'h4444_4444, 8'd20);
    cyc("R6", 1, 1, 0, 32'h0000_4000, 32'h0, 8'd15);
    cyc("R5", 1, 0, 0, 32'h0000_0002, 32'h0, 8'd15);
    for (int k = 0; k < 600; k++) begin
      bit rq;
      bit dr;
      bit fl;
      logic [7:0] cn;
      string tg;
      rq = ($urandom % 4) != 0;
      dr = $urandom % 2;
      fl = $urandom % 2;
      cn = 8'($urandom);
      if (!rq) tg = "R9";
      else if (!fl && (cn % 32) > 16) tg = "R8";
      else if ((cn % 32) == 0) tg = "R4";
      else if (!fl) tg = "R7";
      else if (cn > 31) tg = "R3";
      else tg = dr ? "R2" : "R1";
      cyc(tg, rq, dr, fl, $urandom, $urandom, cn);
    end
    cyc("R9", 0, 0, 1, 32'h0, 32'h0, 8'd0);
    @(negedge clk);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule